// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It tracks the sixteen-state test port state machine from the test mode select line on each rising test clock edge. It holds a five-bit instruction register, a one-bit pass-through register and a 32-bit identification register, and it multiplexes the selected register onto the serial data output. The output changes on the falling edge and is enabled only while data is being shifted.

The current instruction is decoded into mode signals for a boundary register that sits outside this block. These are a select for the boundary register, a test-mode flag that hands pin control to the boundary register, and a flag that floats every device output. The block also gives per-state capture, shift and update strobes, qualified by the boundary select. The boundary register's serial output comes back in on its own port and reaches the serial output through the multiplexer.

An optional active-low test reset forces the state machine into its reset state at once. Its release is synchronised to the test clock. All logic is static, so the clock may be held stopped at either level.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: While `trst_n` is low, the state machine sits in Test-Logic-Reset, `tdo_oe` is 0 and the identification instruction is active. After `trst_n` rises, the state machine ignores TMS on the first two rising TCK edges and moves on the third.
- R2: Five rising edges with TMS high reach Test-Logic-Reset from any state, and that state loads the identification instruction (opcode 00100).
- R3: Capture-IR loads 00001 into the instruction shift stage. Shift-IR moves bits from TDI toward TDO, least significant bit first. The shifted value becomes the active instruction on leaving Update-IR.
- R4: The identification opcode 00100 selects a 32-bit register. Bit 0 is 1, bits 11:1 are 00000101111, bits 27:12 are the part-number parameter and bits 31:28 are the version parameter. It is captured in Capture-DR and shifted out least significant bit first.
- R5: The bypass opcode 11111, opcode 00011, opcode 10000 and every opcode not listed in R4, R6, R7 or R8 select a one-bit register. That register captures 0 in Capture-DR and delays TDI by one clock in Shift-DR.
- R6: Opcode 01110 selects the one-bit register, drives `bnd_highz` high and keeps `bnd_sel` and `bnd_test_mode` low.
- R7: Opcode 01111 selects the one-bit register and drives `bnd_test_mode` high with `bnd_highz` low, so the pins keep the values held in the boundary register.
- R8: Opcodes 00000, 00001 and 00010 drive `bnd_sel` high and route `bnd_so` to TDO. `bnd_test_mode` is high for 00000 and 00010 only.
- R9: TDO and `tdo_oe` change on the falling TCK edge. `tdo_oe` is high only after a falling edge spent in Shift-IR or Shift-DR.
- R10: `bnd_capture`, `bnd_shift` and `bnd_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while `bnd_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| bnd_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for TDO |
| bnd_sel | output | 1 | Boundary register is the selected data register |
| bnd_test_mode | output | 1 | Boundary register drives the pins |
| bnd_highz | output | 1 | All device outputs disabled |
| bnd_capture | output | 1 | Boundary capture strobe (Capture-DR) |
| bnd_shift | output | 1 | Boundary shift strobe (Shift-DR) |
| bnd_update | output | 1 | Boundary update strobe (Update-DR) |

## Verification
The assertions assume that TMS, TDI and `bnd_so` are stable around each rising TCK edge. They also assume that `trst_n` changes away from clock edges, so the sampled reset and the state agree. The stimulus sets every input about a quarter period after the falling edge, including the mid-shift reset pulse. It reads TDO at the same point, when the falling-edge register has settled.

// File: rtl/jtag_tap_pkg.sv
`timescale 1ns/1ps
package jtag_tap_pkg;

  localparam int IR_W   = 5;
  localparam int MFR_W  = 11;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    SRC_BYPASS, SRC_IDENT, SRC_BOUNDARY
  } dr_src_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 5'b00000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 5'b00001;
  localparam logic [IR_W-1:0] OP_INTEST   = 5'b00010;
  localparam logic [IR_W-1:0] OP_IDCODE   = 5'b00100;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 5'b01110;
  localparam logic [IR_W-1:0] OP_CLAMP    = 5'b01111;
  localparam logic [IR_W-1:0] OP_BYPASS   = 5'b11111;

  localparam logic [IR_W-1:0]  IR_CAPTURE = 5'b00001;
  localparam logic [MFR_W-1:0] MFR_CODE   = 11'b00000101111;

endpackage

// File: rtl/jtag_rst_sync.sv
`timescale 1ns/1ps
module jtag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_d;
  end
endmodule

// File: rtl/jtag_ir_decode.sv
`timescale 1ns/1ps
module jtag_ir_decode
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sr,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so,
  output dr_src_e         dr_src,
  output logic            test_mode,
  output logic            highz
);
  logic            sr_en;
  logic [IR_W-1:0] sr_d;
  logic            ir_en;
  logic [IR_W-1:0] ir_d;

  always_comb begin
    sr_en = 1'b0;
    sr_d  = ir_sr;
    if (state == ST_CAP_IR) begin
      sr_en = 1'b1;
      sr_d  = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      sr_en = 1'b1;
      sr_d  = {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == ST_TLR) begin
      ir_en = 1'b1;
      ir_d  = OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      ir_en = 1'b1;
      ir_d  = ir_sr;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sr <= IR_CAPTURE;
    else if (sr_en) ir_sr <= sr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= OP_IDCODE;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir_so = ir_sr[0];

  always_comb begin
    dr_src    = SRC_BYPASS;
    test_mode = 1'b0;
    highz     = 1'b0;
    unique case (ir_q)
      OP_EXTEST: begin dr_src = SRC_BOUNDARY; test_mode = 1'b1; end
      OP_SAMPLE: begin dr_src = SRC_BOUNDARY; end
      OP_INTEST: begin dr_src = SRC_BOUNDARY; test_mode = 1'b1; end
      OP_IDCODE: begin dr_src = SRC_IDENT; end
      OP_HIGHZ:  begin highz = 1'b1; end
      OP_CLAMP:  begin test_mode = 1'b1; end
      default:   begin dr_src = SRC_BYPASS; end
    endcase
  end
endmodule

// File: rtl/jtag_dr_path.sv
`timescale 1ns/1ps
module jtag_dr_path
  import jtag_tap_pkg::*;
#(
  parameter int                  ID_VER_W   = 4,
  parameter int                  ID_PART_W  = 16,
  parameter logic [ID_VER_W-1:0]  ID_VERSION = '0,
  parameter logic [ID_PART_W-1:0] ID_PART    = '0
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  dr_src_e    dr_src,
  input  logic       bnd_so,
  output logic       byp_q,
  output logic       dr_so
);
  localparam int ID_W = ID_VER_W + ID_PART_W + MFR_W + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, MFR_CODE, 1'b1};

  logic            cap_en;
  logic            sh_en;
  logic            byp_en;
  logic            byp_d;
  logic            id_en;
  logic [ID_W-1:0] id_d;
  logic [ID_W-1:0] id_sr;

  assign cap_en = (state == ST_CAP_DR);
  assign sh_en  = (state == ST_SH_DR);

  always_comb begin
    byp_en = 1'b0;
    byp_d  = byp_q;
    if (dr_src == SRC_BYPASS) begin
      if (cap_en) begin
        byp_en = 1'b1;
        byp_d  = 1'b0;
      end else if (sh_en) begin
        byp_en = 1'b1;
        byp_d  = tdi;
      end
    end
  end

  always_comb begin
    id_en = 1'b0;
    id_d  = id_sr;
    if (dr_src == SRC_IDENT) begin
      if (cap_en) begin
        id_en = 1'b1;
        id_d  = ID_VALUE;
      end else if (sh_en) begin
        id_en = 1'b1;
        id_d  = {tdi, id_sr[ID_W-1:1]};
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_sr <= '0;
    else if (id_en) id_sr <= id_d;
  end

  always_comb begin
    unique case (dr_src)
      SRC_IDENT:    dr_so = id_sr[0];
      SRC_BOUNDARY: dr_so = bnd_so;
      default:      dr_so = byp_q;
    endcase
  end
endmodule

// File: rtl/jtag_tap_ctrl.sv
`timescale 1ns/1ps
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int                   RST_STAGES = 2,
  parameter int                   ID_VER_W   = 4,
  parameter int                   ID_PART_W  = 16,
  parameter logic [ID_VER_W-1:0]  ID_VERSION = 4'h1,
  parameter logic [ID_PART_W-1:0] ID_PART    = 16'h0F2A
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bnd_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bnd_sel,
  output logic bnd_test_mode,
  output logic bnd_highz,
  output logic bnd_capture,
  output logic bnd_shift,
  output logic bnd_update
);
  logic            rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  dr_src_e         dr_src;
  logic            byp_q;
  logic            dr_so;
  logic            tdo_d;
  logic            oe_d;

  jtag_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n)
  );

  jtag_tap_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(state)
  );

  jtag_ir_decode u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .ir_sr(ir_sr), .ir_q(ir_q), .ir_so(ir_so), .dr_src(dr_src),
    .test_mode(bnd_test_mode), .highz(bnd_highz)
  );

  jtag_dr_path #(
    .ID_VER_W(ID_VER_W), .ID_PART_W(ID_PART_W),
    .ID_VERSION(ID_VERSION), .ID_PART(ID_PART)
  ) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .dr_src(dr_src), .bnd_so(bnd_so), .byp_q(byp_q), .dr_so(dr_so)
  );

  assign bnd_sel     = (dr_src == SRC_BOUNDARY);
  assign bnd_capture = bnd_sel && (state == ST_CAP_DR);
  assign bnd_shift   = bnd_sel && (state == ST_SH_DR);
  assign bnd_update  = bnd_sel && (state == ST_UPD_DR);

  assign tdo_d = (state == ST_SH_IR) ? ir_so : dr_so;
  assign oe_d  = (state == ST_SH_IR) || (state == ST_SH_DR);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end
endmodule

// File: rtl/jtag_tap_checker.sv
`timescale 1ns/1ps
module jtag_tap_checker
  import jtag_tap_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            rst_n,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_sr,
  input logic [IR_W-1:0] ir_q,
  input dr_src_e         dr_src,
  input logic            byp_q,
  input logic            tdo_oe,
  input logic            bnd_test_mode,
  input logic            bnd_highz
);
  assert_trst_forces_reset_R1: assert property (@(posedge tck)
    !trst_n |-> state == ST_TLR);

  assert_reset_loads_idcode_R2: assert property (@(posedge tck) disable iff (!rst_n)
    state == ST_TLR |=> ir_q == OP_IDCODE);

  assert_capture_ir_pattern_R3: assert property (@(posedge tck) disable iff (!rst_n)
    state == ST_CAP_IR |=> ir_sr[1:0] == 2'b01);

  assert_bypass_captures_zero_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && dr_src == SRC_BYPASS) |=> !byp_q);

  assert_highz_uses_bypass_R6: assert property (@(posedge tck) disable iff (!rst_n)
    bnd_highz |-> (dr_src == SRC_BYPASS && !bnd_test_mode));

  assert_oe_only_in_shift_R9: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
endmodule

bind jtag_tap_ctrl jtag_tap_checker u_chk (
  .tck(tck), .trst_n(trst_n), .rst_n(rst_n), .state(state),
  .ir_sr(ir_sr), .ir_q(ir_q), .dr_src(dr_src), .byp_q(byp_q),
  .tdo_oe(tdo_oe), .bnd_test_mode(bnd_test_mode), .bnd_highz(bnd_highz)
);

// File: tb/jtag_tap_ctrl_bench.sv
`timescale 1ns/1ps
module jtag_tap_ctrl_bench;
  localparam logic [3:0]  VER  = 4'h3;
  localparam logic [15:0] PART = 16'hA5C1;
  // R4 layout: version, part number, manufacturer 00000101111, lsb 1
  localparam logic [31:0] ID_EXP = {VER, PART, 11'b00000101111, 1'b1};

  logic tck = 1'b0;
  logic trst_n, tms, tdi, bnd_so;
  logic tdo, tdo_oe, bnd_sel, bnd_test_mode, bnd_highz;
  logic bnd_capture, bnd_shift, bnd_update;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string cur_req = "R9";
  bit exp_q[$];

  always #2 tck = ~tck;

  jtag_tap_ctrl #(.ID_VERSION(VER), .ID_PART(PART)) u_jtag_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bnd_so(bnd_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bnd_sel(bnd_sel),
    .bnd_test_mode(bnd_test_mode), .bnd_highz(bnd_highz),
    .bnd_capture(bnd_capture), .bnd_shift(bnd_shift), .bnd_update(bnd_update)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  // monitor: pops one expected bit per falling edge with the output enabled
  initial begin
    forever begin
      @(negedge tck);
      #1;
      if (tdo_oe === 1'b1) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL %s unexpected shift: got tdo_oe 1 expected 0", cur_req);
        end else begin
          bit e;
          e = exp_q.pop_front();
          if (tdo !== e) begin
            n_fail++;
            $display("FAIL %s tdo bit: got %0b expected %0b", cur_req, tdo, e);
          end
        end
      end
    end
  end

  // inputs change one quarter period after the falling edge
  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic shift_ir(input logic [4:0] op);
    exp_q.push_back(1'b1);                       // R3 capture 00001, lsb first
    for (int i = 1; i < 5; i++) exp_q.push_back(1'b0);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(i == 4, op[i]);
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [39:0] din, input logic [39:0] dexp);
    for (int i = 0; i < n; i++) exp_q.push_back(dexp[i]);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic bypass_run(input string req, input logic [7:0] d);
    cur_req = req;
    shift_dr(8, {32'h0, d}, {32'h0, d[6:0], 1'b0});
  endtask

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; bnd_so = 1'b0;
    repeat (3) @(posedge tck);
    @(negedge tck); #1;

    // R1 reset state
    chk("R1", "tdo_oe in reset", tdo_oe, 1'b0);
    chk("R1", "bnd_sel in reset", bnd_sel, 1'b0);
    chk("R1", "bnd_highz in reset", bnd_highz, 1'b0);
    chk("R1", "bnd_test_mode in reset", bnd_test_mode, 1'b0);

    // R1 release held for two rising edges
    trst_n = 1'b1;
    tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R1", "tdo_oe after synchronised release", tdo_oe, 1'b0);

    // R1 R4 identification active after reset
    cur_req = "R4";
    shift_dr(32, 40'h0, {8'h0, ID_EXP});

    // R3 R8 sample: only correct bit order yields boundary select
    cur_req = "R3";
    shift_ir(5'b00001);
    chk("R8", "sample bnd_sel", bnd_sel, 1'b1);
    chk("R8", "sample bnd_test_mode", bnd_test_mode, 1'b0);
    chk("R8", "sample bnd_highz", bnd_highz, 1'b0);
    bnd_so = 1'b1;
    cur_req = "R8";
    shift_dr(8, 40'h0, 40'hFF);

    // R8 R10 extest with strobes
    cur_req = "R3";
    shift_ir(5'b00000);
    chk("R8", "extest bnd_sel", bnd_sel, 1'b1);
    chk("R8", "extest bnd_test_mode", bnd_test_mode, 1'b1);
    cur_req = "R10";
    for (int i = 0; i < 3; i++) exp_q.push_back(1'b1);
    tick(1, 0);
    chk("R10", "capture strobe outside capture", bnd_capture, 1'b0);
    tick(0, 0);
    chk("R10", "capture strobe", bnd_capture, 1'b1);
    chk("R10", "shift strobe in capture", bnd_shift, 1'b0);
    tick(0, 0);
    chk("R10", "shift strobe", bnd_shift, 1'b1);
    chk("R10", "capture strobe in shift", bnd_capture, 1'b0);
    tick(0, 0); tick(0, 0);
    tick(1, 0);
    chk("R10", "shift strobe in exit", bnd_shift, 1'b0);
    tick(1, 0);
    chk("R10", "update strobe", bnd_update, 1'b1);
    tick(0, 0);
    chk("R10", "update strobe in idle", bnd_update, 1'b0);

    cur_req = "R3";
    shift_ir(5'b00010);
    chk("R8", "intest bnd_sel", bnd_sel, 1'b1);
    chk("R8", "intest bnd_test_mode", bnd_test_mode, 1'b1);

    // R6 high-Z with boundary output held at 1 to expose misrouting
    cur_req = "R3";
    shift_ir(5'b01110);
    chk("R6", "highz flag", bnd_highz, 1'b1);
    chk("R6", "highz bnd_sel", bnd_sel, 1'b0);
    chk("R6", "highz bnd_test_mode", bnd_test_mode, 1'b0);
    bypass_run("R6", 8'b10110010);
    chk("R6", "highz capture strobe stays low", bnd_capture, 1'b0);

    cur_req = "R3";
    shift_ir(5'b01111);
    chk("R7", "clamp test mode", bnd_test_mode, 1'b1);
    chk("R7", "clamp highz", bnd_highz, 1'b0);
    chk("R7", "clamp bnd_sel", bnd_sel, 1'b0);
    bypass_run("R7", 8'b01101101);

    // R5 bypass and unlisted opcodes
    cur_req = "R3"; shift_ir(5'b11111);
    chk("R5", "bypass bnd_sel", bnd_sel, 1'b0);
    bypass_run("R5", 8'b11001011);
    cur_req = "R3"; shift_ir(5'b10000);
    chk("R5", "opcode 10000 bnd_sel", bnd_sel, 1'b0);
    bypass_run("R5", 8'b10011110);
    cur_req = "R3"; shift_ir(5'b10101);
    bypass_run("R5", 8'b01010111);
    cur_req = "R3"; shift_ir(5'b00011);
    bypass_run("R5", 8'b11100001);

    // R4 identification selected explicitly, nonzero fill
    cur_req = "R3"; shift_ir(5'b00100);
    cur_req = "R4";
    shift_dr(32, 40'hFF_FFFF_FFFF, {8'h0, ID_EXP});

    // R2 five TMS-high edges restore identification
    cur_req = "R3"; shift_ir(5'b00000);
    bnd_so = 1'b0;
    repeat (5) tick(1, 0);
    tick(0, 0);
    chk("R2", "bnd_sel after tms reset", bnd_sel, 1'b0);
    chk("R2", "bnd_test_mode after tms reset", bnd_test_mode, 1'b0);
    cur_req = "R2";
    shift_dr(32, 40'h0, {8'h0, ID_EXP});

    // R1 asynchronous reset in the middle of a shift
    cur_req = "R3"; shift_ir(5'b11111);
    cur_req = "R1";
    exp_q.push_back(1'b0);
    tick(1, 0); tick(0, 0); tick(0, 0);
    #0.2;
    trst_n = 1'b0;
    #0.3;
    chk("R1", "tdo_oe cleared at once by trst_n", tdo_oe, 1'b0);
    @(posedge tck); @(negedge tck); #1;
    chk("R1", "tdo_oe during trst_n", tdo_oe, 1'b0);
    trst_n = 1'b1;
    tick(0, 0); tick(0, 0); tick(0, 0);
    shift_dr(32, 40'h0, {8'h0, ID_EXP});

    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 leftover expected bits: got %0d expected 0", exp_q.size());
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule